// File: doc/BRIEF.md
# Exception Entry and Mode-Stack Controller

This block keeps the exception-related control registers of a small 32-bit MIPS-style processor: the status word with its mode stack, the cause word, the exception return address and a fixed revision number. When the pipeline reports a synchronous fault, or when an enabled external interrupt is pending, the block takes the exception. It saves the return address, corrects that address for a branch-delay slot, rewrites the cause word, pushes the kernel/interrupt-enable mode stack and drives the handler address onto `pc_out`.

A small finite-state machine decides when an entry happens. In state `ST_RUN` the block accepts an exception request or an enabled interrupt. The transition `RUN->ENTER` is taken on the clock edge that updates all registers. `ST_ENTER` lasts exactly one cycle, during which `exc_take` is high and `pc_out` holds the vector. The transition `ENTER->RUN` is unconditional, and a request seen during `ST_ENTER` is dropped. A return-from-exception strobe pops the mode stack. A register-select port lets software read every register and write the writable ones.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, `pc_out` is 0xBFC00000, Status is 0x10600000, Cause and EPC are 0, `exc_take` is 0, and a read with select 3 returns 0x00000002.
- R2: On entry, Cause becomes (old Cause AND 0x300) OR the entry cause word. Bit 31 is set when the entry is in a delay slot.
- R3: On entry, EPC is loaded with `cur_pc` minus 4 when `in_delay_slot` is set for the entry, and with `cur_pc` otherwise.
- R4: During the `exc_take` cycle, `pc_out` is 0xBFC00180 if Status bit 22 was set at entry and 0x80000080 if it was clear.
- R5: On entry, Status bits 5:2 receive the old bits 3:0 and bits 1:0 become 0. All other Status bits are unchanged.
- R6: An interrupt entry happens when (irq_status AND irq_mask) is nonzero and Status bits 10 and 0 are both 1. It uses cause word 0x400 with the delay-slot flag forced clear, so EPC equals `cur_pc`. If either Status bit is 0, a pending masked line causes no entry.
- R7: An `rfe` pulse loads Status bits 3:0 from bits 5:2 and leaves bits 5:4 and all higher bits unchanged.
- R8: `exc_take` is high for exactly one cycle, the cycle after the accepting edge. A request held into that cycle is not accepted a second time.
- R9: In the same cycle, an exception request wins over an interrupt. An entry also wins over an `rfe` pulse and over a software write, and both of those are discarded.
- R10: Software port: select 0 is Status (all bits writable), select 1 is Cause (only bits 9:8 writable), select 2 is EPC (read-only), select 3 is the revision (read-only). Reads are combinational on `sw_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | Address of the instruction being excepted |
| in_delay_slot | input | 1 | That instruction sits in a branch-delay slot |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause_in | input | 32 | Cause word ORed into Cause on a requested exception |
| irq_status | input | 11 | Pending interrupt lines |
| irq_mask | input | 11 | Interrupt line enables |
| rfe | input | 1 | Return-from-exception strobe, pops the mode stack |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 2 | Register select: 0 Status, 1 Cause, 2 EPC, 3 revision |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Selected register value |
| pc_out | output | 32 | Current redirect target, the reset address or the last vector |
| exc_take | output | 1 | One-cycle entry pulse |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Exception return address |

## Verification
The bench goes after the delay-slot correction first. A design that skipped it would return to the slot instead of the branch, or would leave Cause bit 31 clear. An interrupt is raised while the delay flag is held high, so a design that leaked the flag into interrupt entries shows a wrong EPC. The bench checks that masked interrupts with either enable bit clear change nothing. It checks that a request held through the pulse does not produce a second entry. When an entry coincides with a return strobe and a software write, the bench checks that only the entry's mode-stack push is seen in Status. A design with the wrong priority would leave the written or popped value there instead.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_ENTER = 1'b1
    } exc_state_e;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_REV    = 2'd3
    } reg_sel_e;

    localparam int BEV_BIT   = 22;
    localparam int IM_BIT    = 10;
    localparam int IE_BIT    = 0;
    localparam int BD_BIT    = 31;
    localparam int SWI_LO    = 8;
    localparam int SWI_HI    = 9;
    localparam int STACK_W   = 6;
    localparam int LEVEL_W   = 2;

    localparam logic [31:0] HW_IRQ_CAUSE = 32'h0000_0400;

endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
    parameter int NIRQ = 11
) (
    input  logic [NIRQ-1:0] irq_status,
    input  logic [NIRQ-1:0] irq_mask,
    input  logic            glob_en,
    input  logic            line_en,
    output logic            irq_fire
);
    logic [NIRQ-1:0] hit;

    // per-line qualification
    for (genvar i = 0; i < NIRQ; i++) begin : g_line
        assign hit[i] = irq_status[i] & irq_mask[i];
    end

    assign irq_fire = (|hit) & glob_en & line_en;

endmodule

// File: rtl/exc_ctrl_fsm.sv
module exc_ctrl_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_req,
    input  logic irq_fire,
    output logic enter,
    output logic use_irq,
    output logic exc_take
);
    exc_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (exc_req || irq_fire) state_d = ST_ENTER;
            ST_ENTER: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        enter    = 1'b0;
        use_irq  = 1'b0;
        exc_take = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                enter   = exc_req | irq_fire;
                use_irq = irq_fire & ~exc_req;
            end
            ST_ENTER: exc_take = 1'b1;
        endcase
    end

    assert_enter_only_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> !enter);

endmodule

// File: rtl/exc_status_stack.sv
module exc_status_stack
    import exc_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter logic [31:0] STATUS_RST = 32'h1060_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic            wr,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] status
);
    localparam int PUSH_SRC = STACK_W - LEVEL_W;

    logic [XLEN-1:0] status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= XLEN'(STATUS_RST);
        end else if (push) begin
            status_q <= {status_q[XLEN-1:STACK_W], status_q[PUSH_SRC-1:0], {LEVEL_W{1'b0}}};
        end else if (wr) begin
            status_q <= wdata;
        end else if (pop) begin
            status_q <= {status_q[XLEN-1:PUSH_SRC], status_q[STACK_W-1:LEVEL_W]};
        end
    end

    assign status = status_q;

    assert_pop_keeps_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !wr) |=> status_q[STACK_W-1:PUSH_SRC] == $past(status_q[STACK_W-1:PUSH_SRC]));

endmodule

// File: rtl/exc_cause_epc.sv
module exc_cause_epc
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter,
    input  logic            bd,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] cause_val,
    input  logic            sw_wr,
    input  logic [SWI_HI:SWI_LO] sw_bits,
    output logic [XLEN-1:0] cause,
    output logic [XLEN-1:0] epc
);
    localparam logic [XLEN-1:0] KEEP_MASK = XLEN'(32'h0000_0300);
    localparam logic [XLEN-1:0] BD_MASK   = XLEN'(1) << BD_BIT;

    logic [XLEN-1:0] cause_q, epc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else if (enter) begin
            cause_q <= (cause_q & KEEP_MASK) | cause_val | (bd ? BD_MASK : '0);
            epc_q   <= bd ? (pc - XLEN'(4)) : pc;
        end else if (sw_wr) begin
            cause_q[SWI_HI:SWI_LO] <= sw_bits;
        end
    end

    assign cause = cause_q;
    assign epc   = epc_q;

    assert_bd_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> cause_q[BD_BIT] == $past(bd | cause_val[BD_BIT]));

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          NIRQ       = 11,
    parameter logic [31:0] RESET_PC   = 32'hBFC0_0000,
    parameter logic [31:0] VEC_BOOT   = 32'hBFC0_0180,
    parameter logic [31:0] VEC_NORM   = 32'h8000_0080,
    parameter logic [31:0] STATUS_RST = 32'h1060_0000,
    parameter logic [31:0] REV_ID     = 32'h0000_0002
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            in_delay_slot,
    input  logic            exc_req,
    input  logic [XLEN-1:0] exc_cause_in,
    input  logic [NIRQ-1:0] irq_status,
    input  logic [NIRQ-1:0] irq_mask,
    input  logic            rfe,
    input  logic            sw_we,
    input  logic [1:0]      sw_sel,
    input  logic [XLEN-1:0] sw_wdata,
    output logic [XLEN-1:0] sw_rdata,
    output logic [XLEN-1:0] pc_out,
    output logic            exc_take,
    output logic [XLEN-1:0] status_o,
    output logic [XLEN-1:0] cause_o,
    output logic [XLEN-1:0] epc_o
);
    logic            irq_fire, enter, use_irq;
    logic            ent_bd;
    logic [XLEN-1:0] ent_cause;
    logic            wr_status, wr_cause, pop_ok;
    logic [XLEN-1:0] status_w, cause_w, epc_w;
    logic [XLEN-1:0] pc_q;
    reg_sel_e        sel;

    exc_irq_gate #(.NIRQ(NIRQ)) u_gate (
        .irq_status (irq_status),
        .irq_mask   (irq_mask),
        .glob_en    (status_w[IE_BIT]),
        .line_en    (status_w[IM_BIT]),
        .irq_fire   (irq_fire)
    );

    exc_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .exc_req  (exc_req),
        .irq_fire (irq_fire),
        .enter    (enter),
        .use_irq  (use_irq),
        .exc_take (exc_take)
    );

    // entry source selection: a request beats an interrupt
    assign ent_bd    = use_irq ? 1'b0 : in_delay_slot;
    assign ent_cause = use_irq ? XLEN'(HW_IRQ_CAUSE) : exc_cause_in;

    // entry beats software write and return strobe
    assign sel       = reg_sel_e'(sw_sel);
    assign wr_status = sw_we & (sel == SEL_STATUS) & ~enter;
    assign wr_cause  = sw_we & (sel == SEL_CAUSE) & ~enter;
    assign pop_ok    = rfe & ~enter;

    exc_status_stack #(.XLEN(XLEN), .STATUS_RST(STATUS_RST)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (enter),
        .pop    (pop_ok),
        .wr     (wr_status),
        .wdata  (sw_wdata),
        .status (status_w)
    );

    exc_cause_epc #(.XLEN(XLEN)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter     (enter),
        .bd        (ent_bd),
        .pc        (cur_pc),
        .cause_val (ent_cause),
        .sw_wr     (wr_cause),
        .sw_bits   (sw_wdata[SWI_HI:SWI_LO]),
        .cause     (cause_w),
        .epc       (epc_w)
    );

    // redirect target
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= XLEN'(RESET_PC);
        else if (enter) pc_q <= status_w[BEV_BIT] ? XLEN'(VEC_BOOT) : XLEN'(VEC_NORM);
    end

    // software read path
    always_comb begin
        sw_rdata = '0;
        unique case (sel)
            SEL_STATUS: sw_rdata = status_w;
            SEL_CAUSE:  sw_rdata = cause_w;
            SEL_EPC:    sw_rdata = epc_w;
            SEL_REV:    sw_rdata = XLEN'(REV_ID);
        endcase
    end

    assign pc_out   = pc_q;
    assign status_o = status_w;
    assign cause_o  = cause_w;
    assign epc_o    = epc_w;

    assert_take_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> !exc_take);

    assert_vector_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> pc_out == (status_w[BEV_BIT] ? XLEN'(VEC_BOOT) : XLEN'(VEC_NORM)));

    assert_stack_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_take) |-> (status_w[LEVEL_W-1:0] == '0) &&
                            (status_w[STACK_W-1:LEVEL_W] == $past(status_w[STACK_W-LEVEL_W-1:0])));

    assert_epc_fix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_take) |-> epc_w == (($past(exc_req) && $past(in_delay_slot)) ?
                                      ($past(cur_pc) - XLEN'(4)) : $past(cur_pc)));

    assert_swbits_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_take) |-> cause_w[SWI_HI:SWI_LO] == $past(cause_w[SWI_HI:SWI_LO]));

endmodule

// File: tb/exc_entry_unit_tb.sv
`timescale 1ns/1ps
module exc_entry_unit_tb;

    localparam int NIRQ = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        in_delay_slot = 1'b0;
    logic        exc_req = 1'b0;
    logic [31:0] exc_cause_in = '0;
    logic [NIRQ-1:0] irq_status = '0;
    logic [NIRQ-1:0] irq_mask = '0;
    logic        rfe = 1'b0;
    logic        sw_we = 1'b0;
    logic [1:0]  sw_sel = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata, pc_out, status_o, cause_o, epc_o;
    logic        exc_take;

    always #4 clk = ~clk;

    exc_entry_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .in_delay_slot(in_delay_slot),
        .exc_req(exc_req), .exc_cause_in(exc_cause_in), .irq_status(irq_status),
        .irq_mask(irq_mask), .rfe(rfe), .sw_we(sw_we), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .pc_out(pc_out),
        .exc_take(exc_take), .status_o(status_o), .cause_o(cause_o), .epc_o(epc_o)
    );

    typedef struct {
        logic [31:0] pc, status, cause, epc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [31:0] m_status, m_cause, m_epc;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // monitor: every entry pulse must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && exc_take) begin
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 unexpected entry pulse actual=1 expected=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " R4 vector"}, pc_out, e.pc);
                chk({e.tag, " R5 status"}, status_o, e.status);
                chk({e.tag, " R2 cause"}, cause_o, e.cause);
                chk({e.tag, " R3 epc"}, epc_o, e.epc);
            end
        end
    end

    // driver side: compute and push the expected entry result
    task automatic push_entry(string tag, logic [31:0] pc, logic bd, logic [31:0] cval);
        exp_t e;
        e.tag    = tag;
        e.pc     = m_status[22] ? 32'hBFC0_0180 : 32'h8000_0080;
        e.status = (m_status & ~32'h3f) | ((m_status & 32'hf) << 2);
        e.cause  = (m_cause & 32'h300) | cval | (bd ? 32'h8000_0000 : 32'h0);
        e.epc    = bd ? pc - 32'd4 : pc;
        q.push_back(e);
        m_status = e.status; m_cause = e.cause; m_epc = e.epc;
    endtask

    task automatic do_exc(string tag, logic [31:0] pc, logic bd, logic [31:0] cval,
                          bit with_rfe, bit with_wr, bit hold);
        cur_pc = pc; in_delay_slot = bd; exc_cause_in = cval; exc_req = 1'b1;
        rfe = with_rfe; sw_we = with_wr; sw_sel = 2'd0; sw_wdata = 32'hFFFF_FFFF;
        push_entry(tag, pc, bd, cval);
        @(negedge clk);
        rfe = 1'b0; sw_we = 1'b0;
        if (hold) @(negedge clk);
        if (hold) chk("R8 held request not re-accepted", {31'd0, exc_take}, 32'd0);
        exc_req = 1'b0; in_delay_slot = 1'b0;
        @(negedge clk);
    endtask

    task automatic sw_write(logic [1:0] sel, logic [31:0] d);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
        if (sel == 2'd0) m_status = d;
        if (sel == 2'd1) m_cause = (m_cause & ~32'h300) | (d & 32'h300);
    endtask

    task automatic sw_read(string tag, logic [1:0] sel, logic [31:0] exp);
        sw_sel = sel;
        #1;
        chk(tag, sw_rdata, exp);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_status = 32'h1060_0000; m_cause = 0; m_epc = 0;

        // R1 reset state
        chk("R1 pc_out", pc_out, 32'hBFC0_0000);
        chk("R1 status", status_o, 32'h1060_0000);
        chk("R1 cause", cause_o, 32'h0);
        chk("R1 epc", epc_o, 32'h0);
        chk("R1 take", {31'd0, exc_take}, 32'd0);
        sw_read("R1 revision", 2'd3, 32'h0000_0002);

        // R10 write masks
        sw_write(2'd1, 32'hFFFF_FFFF);
        sw_read("R10 cause write mask", 2'd1, 32'h0000_0300);
        sw_write(2'd2, 32'h0000_1234);
        sw_read("R10 epc read-only", 2'd2, 32'h0);
        sw_write(2'd3, 32'h0000_5555);
        sw_read("R10 revision read-only", 2'd3, 32'h0000_0002);

        // R4 boot vector, plain entry
        do_exc("boot", 32'h8001_0000, 1'b0, 32'h24, 1'b0, 1'b0, 1'b0);

        // R5 mode stack push, normal vector
        sw_write(2'd0, 32'h0000_0015);
        do_exc("push", 32'h8001_1000, 1'b0, 32'h10, 1'b0, 1'b0, 1'b0);

        // R3 delay slot correction
        do_exc("delay", 32'h8002_0008, 1'b1, 32'h10, 1'b0, 1'b0, 1'b0);

        // R7 pop
        rfe = 1'b1;
        @(negedge clk);
        rfe = 1'b0;
        m_status = {m_status[31:4], m_status[5:2]};
        chk("R7 rfe pop", status_o, m_status);

        // R6 interrupt entry, delay flag must not leak
        sw_write(2'd1, 32'h0);
        sw_write(2'd0, 32'h0000_0401);
        cur_pc = 32'h8003_0010; in_delay_slot = 1'b1;
        irq_status = 11'h008; irq_mask = 11'h008;
        push_entry("irq", 32'h8003_0010, 1'b0, 32'h400);
        @(negedge clk);
        irq_status = '0; irq_mask = '0; in_delay_slot = 1'b0;
        @(negedge clk);

        // R6 gated interrupts
        sw_write(2'd0, 32'h0000_0401);
        irq_status = 11'h008; irq_mask = 11'h010;
        repeat (3) @(negedge clk);
        chk("R6 mask mismatch no entry", status_o, 32'h0000_0401);
        sw_write(2'd0, 32'h0000_0400);
        irq_mask = 11'h008;
        repeat (3) @(negedge clk);
        chk("R6 global enable clear no entry", status_o, 32'h0000_0400);
        sw_write(2'd0, 32'h0000_0001);
        repeat (3) @(negedge clk);
        chk("R6 line enable clear no entry", status_o, 32'h0000_0001);

        // R9 request beats interrupt
        sw_write(2'd0, 32'h0000_0401);
        do_exc("prio", 32'h0000_0100, 1'b1, 32'h30, 1'b0, 1'b0, 1'b0);
        irq_status = '0; irq_mask = '0;

        // R9 entry beats rfe and software write
        sw_write(2'd0, 32'h0000_0015);
        do_exc("clash", 32'h8004_0000, 1'b0, 32'h20, 1'b1, 1'b1, 1'b0);
        chk("R9 status after clash", status_o, m_status);

        // R8 held request
        do_exc("hold", 32'h8005_0000, 1'b0, 32'h08, 1'b0, 1'b0, 1'b1);

        // R4 boot vector with delay slot, R2 software bits kept
        sw_write(2'd1, 32'h0000_0100);
        sw_write(2'd0, 32'h0040_0003);
        do_exc("bev", 32'h8006_0004, 1'b1, 32'h1C, 1'b0, 1'b0, 1'b0);

        repeat (2) @(negedge clk);
        chk("R8 all entries seen", q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule